// File: doc/BRIEF.md
# I2C Serial Memory Read Engine

This block is the bus-facing read side of a byte-addressed serial memory. It watches a two-wire bus (clock and data, both open-drain), recognises bus start and stop conditions, answers to one fixed 7-bit device address, and returns bytes from a memory array through a synchronous read port. A single persistent address pointer serves every kind of read. A read that opens directly with the read bit set continues from where the previous access left off. A random read first sends a dummy write of a two-byte word address, high byte first, which only reloads the pointer. A repeated start with the read bit then streams data from that address.

The master keeps a read running by acknowledging each byte. Each acknowledge fetches the next byte at pointer+1, and the pointer wraps from the top of the array to zero. A missing acknowledge ends the stream. The data line is driven as an active-low output enable, and the block only changes it while the bus clock is low. Both bus inputs pass through synchronizers, so the system clock must run well above the bus clock.

Top module: `i2c_rd_engine`

## Requirements
- R1: After reset `sda_oe` and `mem_rd_en` are 0 and the pointer is 0, so the first read with no prior address load returns the byte at address 0.
- R2: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. A start in the middle of any byte restarts device-address reception. A stop returns the engine to idle. Neither one changes the pointer.
- R3: The engine pulls data low in the ninth clock of the first byte after a start only when bits 7:1 of that byte equal `DEV_ADDR`. On a mismatch it acknowledges nothing and ignores the bus until the next start, and the pointer stays as it was.
- R4: Data bytes go out most significant bit first. `sda_oe` high means data is pulled low, and `sda_oe` changes only while `scl_i` is low.
- R5: After a device byte with bit 0 = 0, the engine acknowledges two address bytes, high then low. Their low `ADDR_W` bits, taken from {high,low}, load the pointer, and the upper bits are ignored. A third write byte gets no acknowledge.
- R6: When the master pulls data low in the ninth clock after a data byte, the next byte comes from pointer+1. When it leaves data high, the engine releases the line and sends no more data.
- R7: After the byte at `MEM_DEPTH-1`, the next byte comes from address 0.
- R8: The pointer keeps its value between transfers. After a transfer whose last byte came from address N, a read with no address load returns address N+1.
- R9: Each transmitted byte issues exactly one single-cycle `mem_rd_en` pulse, with `mem_rd_addr` equal to that byte's address. Data is taken from `mem_rd_data` on the cycle after the pulse, before the byte's first bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_rd_en | output | 1 | Single-cycle read request to the array |
| mem_rd_addr | output | ADDR_W | Array address of the request |
| mem_rd_data | input | 8 | Array data, valid the cycle after `mem_rd_en` |

## Verification
A bus edge reaches the engine about three system cycles after it appears on the pins: two synchronizer flops plus one history flop. Acknowledge and data-bit drives therefore settle about four cycles into a clock-low phase that lasts sixteen cycles. The bench master changes data a quarter bit into the low phase and samples a quarter bit into the high phase, so each sample falls many cycles after the result is due. A memory read takes two cycles from the pulse to the loaded shift byte, well inside one half bit. Read-pulse counts are compared only after the closing stop. Driver tasks queue the expected acknowledge and data values, and the monitor pairs each one with the observed bit or byte in the order they occur.

// File: rtl/i2c_rd_pkg.sv
// Shared types for the serial memory read engine.
// Assumes: one bus event at most per system clock cycle.
package i2c_rd_pkg;

    // Byte-level phase of the bus engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RX_DEV,
        RX_AHI,
        RX_ALO,
        RX_IGN
    } rx_kind_t;

    // Decoded bus events, one cycle wide each
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_rd_linesync.sv
// Synchronises the bus clock and data pins and decodes edges and
// start/stop conditions. Assumes the bus idles high and that clk is
// at least several times faster than the bus clock.
module i2c_rd_linesync
    import i2c_rd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_old, sda_now, sda_old;

    // Shift pins through the synchronizer and history stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    // Decode edges and start/stop from current and previous samples
    always_comb begin
        ev.rise  = scl_now & ~scl_old;
        ev.fall  = ~scl_now & scl_old;
        ev.start = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop  = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda   = sda_now;
    end

endmodule

// File: rtl/i2c_rd_addrctr.sv
// Persistent array pointer: loads from a dummy write, steps by one
// per fetched byte and wraps from TOP_ADDR to zero.
module i2c_rd_addrctr #(
    parameter int ADDR_W   = 12,
    parameter int TOP_ADDR = 4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] cnt
);

    // Hold, load or advance the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= (cnt == ADDR_W'(TOP_ADDR)) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_rd_fsm.sv
// Byte and bit sequencer: receives device and word-address bytes,
// drives acknowledges, shifts out data and reads the master's
// acknowledge. Assumes memory data arrives one cycle after rd_req.
module i2c_rd_fsm
    import i2c_rd_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              rd_req,
    output logic              ld,
    output logic [ADDR_W-1:0] ld_val
);

    bus_st_t    state;
    rx_kind_t   kind;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] hi_byte;
    logic [7:0] tx_byte;
    logic       is_read;
    logic       rd_pend;
    logic       ack_ok;

    // Sequence bus phases, drive the line and request fetches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= RX_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            hi_byte <= '0;
            tx_byte <= '0;
            is_read <= 1'b0;
            rd_pend <= 1'b0;
            ack_ok  <= 1'b0;
            sda_oe  <= 1'b0;
            rd_req  <= 1'b0;
            ld      <= 1'b0;
            ld_val  <= '0;
        end else begin
            rd_req  <= 1'b0;
            ld      <= 1'b0;
            rd_pend <= rd_req;
            if (rd_pend) begin
                tx_byte <= rd_data;
            end
            if (ev.start) begin
                state  <= ST_RX;
                kind   <= RX_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            case (kind)
                                RX_DEV: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        sda_oe  <= 1'b1;
                                        state   <= ST_ACK;
                                        is_read <= shreg[0];
                                        rd_req  <= shreg[0];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_AHI: begin
                                    hi_byte <= shreg;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                                RX_ALO: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    ld     <= 1'b1;
                                    ld_val <= ADDR_W'({hi_byte, shreg});
                                end
                                default: begin
                                    state <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (kind == RX_DEV && is_read) begin
                                state  <= ST_TX;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                case (kind)
                                    RX_DEV:  kind <= RX_AHI;
                                    RX_AHI:  kind <= RX_ALO;
                                    default: kind <= RX_IGN;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ack_ok <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx_byte[3'd7 - bitcnt[2:0]];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.rise) begin
                            if (!ev.sda) begin
                                ack_ok <= 1'b1;
                                rd_req <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (ev.fall && ack_ok) begin
                            state  <= ST_TX;
                            bitcnt <= '0;
                            sda_oe <= ~tx_byte[7];
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_rd_engine.sv
// Top of the serial memory read engine: pin synchronizer, bus
// sequencer and persistent array pointer. Assumes the array answers
// a read request with data on the following cycle.
module i2c_rd_engine
    import i2c_rd_pkg::*;
#(
    parameter int         MEM_DEPTH   = 4096,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    localparam int        ADDR_W      = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);

    localparam int TOP_ADDR = MEM_DEPTH - 1;

    bus_ev_t           ev;
    logic              rd_req;
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_load_val;
    logic [ADDR_W-1:0] addr_cnt;

    i2c_rd_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rd_fsm #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_data (mem_rd_data),
        .sda_oe  (sda_oe),
        .rd_req  (rd_req),
        .ld      (ctr_load),
        .ld_val  (ctr_load_val)
    );

    i2c_rd_addrctr #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .step     (rd_req),
        .cnt      (addr_cnt)
    );

    assign mem_rd_en   = rd_req;
    assign mem_rd_addr = addr_cnt;

endmodule

// File: rtl/i2c_rd_engine_chk.sv
// Property checker for the read engine, bound onto its top module.
module i2c_rd_engine_chk #(
    parameter int ADDR_W   = 12,
    parameter int TOP_ADDR = 4095
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] addr_cnt,
    input logic              ctr_load
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R4

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R9

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rd_addr != ADDR_W'(TOP_ADDR))
        |=> addr_cnt == ADDR_W'($past(mem_rd_addr) + 1'b1)); // R6

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rd_addr == ADDR_W'(TOP_ADDR)) |=> addr_cnt == '0); // R7

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_en && !ctr_load) |=> $stable(addr_cnt)); // R8

endmodule

bind i2c_rd_engine i2c_rd_engine_chk #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .addr_cnt    (addr_cnt),
    .ctr_load    (ctr_load)
);

// File: tb/i2c_rd_engine_tb.sv
// Scoreboard bench: bus master tasks queue expected values, a monitor
// pairs them with observed acknowledges and data bytes.
module i2c_rd_engine_tb;

    localparam int         DEPTH = 4096;
    localparam int         AW    = 12;
    localparam logic [6:0] DEV   = 7'h50;
    localparam int         Q     = 8;
    localparam int         LIMIT = 200000;

    typedef struct {
        string req;
        int    val;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data = '0;
    logic          sda_line;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    rd_pulses = 0;
    int    oe_bad = 0;
    int    cnt_m = 0;
    item_t exp_q[$];
    int    act_q[$];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_rd_engine #(.MEM_DEPTH(DEPTH), .DEV_ADDR(DEV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 4) ^ 8'h5A);
    endfunction

    // array model with one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(int'(mem_rd_addr));

    always @(posedge clk) if (rst_n && mem_rd_en) rd_pulses++;

    always @(sda_oe) if (rst_n && scl) oe_bad++;

    task automatic compare(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pop expected and observed items in order
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                item_t e;
                int    a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                compare(e.req, a, e.val);
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input string req, input int v);
        item_t it;
        it.req = req;
        it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic bit_io(input logic b, output logic r);
        wait_q(Q); sda_m = b;
        wait_q(Q); scl = 1'b1;
        wait_q(Q); r = sda_line;
        wait_q(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(Q); sda_m = 1'b0;
        wait_q(Q); scl = 1'b1;
        wait_q(Q); sda_m = 1'b1;
        wait_q(4 * Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, input string req, input logic exp_ack);
        logic r;
        push_exp(req, int'(exp_ack));
        for (int i = 7; i >= 0; i--) bit_io(d[i], r);
        bit_io(1'b1, r);
        act_q.push_back(int'(!r));
    endtask

    task automatic partial(input logic [7:0] d, input int nbits);
        logic r;
        for (int i = 7; i > 7 - nbits; i--) bit_io(d[i], r);
    endtask

    task automatic rd_byte(input string req, input logic [7:0] exp, input logic mack);
        logic [7:0] d;
        logic       r;
        push_exp(req, int'(exp));
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(!mack, r);
        act_q.push_back(int'(d));
    endtask

    // read n bytes from the current pointer, then stop
    task automatic cur_read(input string req, input int n);
        int p0;
        p0 = rd_pulses;
        bus_start();
        wr_byte({DEV, 1'b1}, "R3", 1'b1);
        for (int k = 0; k < n; k++) begin
            rd_byte(req, pat(cnt_m), k != n - 1);
            cnt_m = (cnt_m + 1) % DEPTH;
        end
        bus_stop();
        compare("R9", rd_pulses - p0, n);
    endtask

    // dummy write of a 16-bit word address, then sequential read
    task automatic rnd_read(input logic [15:0] a, input int n, input string req);
        bus_start();
        wr_byte({DEV, 1'b0}, "R5", 1'b1);
        wr_byte(a[15:8], "R5", 1'b1);
        wr_byte(a[7:0], "R5", 1'b1);
        cnt_m = int'(a) % DEPTH;
        cur_read(req, n);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_q(6);
        compare("R1", int'(sda_oe), 0);
        compare("R1", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        wait_q(6);
        compare("R1", int'(sda_oe), 0);
        // R1: first read without a load returns address 0
        cur_read("R1", 1);
        // R5: upper word-address bits ignored (0xF234 -> 0x234); R6 stream
        rnd_read(16'hF234, 3, "R6");
        // R8: pointer continues after the stream
        cur_read("R8", 1);
        // R3: wrong device address, no acknowledge, pointer unchanged
        bus_start();
        wr_byte({7'h51, 1'b0}, "R3", 1'b0);
        wr_byte(8'h00, "R3", 1'b0);
        bus_stop();
        cur_read("R3", 1);
        // R7: wrap from the top of the array to 0
        rnd_read(16'h0FFE, 3, "R7");
        // R2: start inside a byte restarts address reception
        bus_start();
        partial({DEV, 1'b0}, 4);
        cur_read("R2", 1);
        // R2: stop inside the high address byte leaves the pointer alone
        bus_start();
        wr_byte({DEV, 1'b0}, "R2", 1'b1);
        partial(8'h0A, 3);
        bus_stop();
        cur_read("R2", 1);
        // R5: third write byte is not acknowledged, load still applies
        bus_start();
        wr_byte({DEV, 1'b0}, "R5", 1'b1);
        wr_byte(8'h01, "R5", 1'b1);
        wr_byte(8'h00, "R5", 1'b1);
        wr_byte(8'h55, "R5", 1'b0);
        bus_stop();
        cnt_m = 16'h0100;
        cur_read("R5", 2);
        // R6: longer sequential stream
        cur_read("R6", 5);
        // R4: data line only moved while the clock was low
        compare("R4", oe_bad, 0);
        wait_q(4);
        compare("R6", exp_q.size() + act_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule